// File: doc/BRIEF.md
# Tile Pixel Buffer with Burst Flush

This block keeps one screen tile of 32 by 16 pixels, each 16 bits, in on-chip storage. A rasterizer stores pixels at tile-relative coordinates, one per cycle, in any order. Each store completes in a single cycle and pays no penalty for jumping around the tile. A later store to the same pixel replaces the earlier one. Before rendering starts, a clear command fills the whole tile with a chosen colour, at one 128-bit word per cycle.

When the tile is finished, a flush request copies the tile to a row-major framebuffer in external memory. The block emits 64 full 128-bit beats over a valid/ready handshake: four beats per tile row, rows top to bottom. Every beat carries eight useful pixels. The address of each beat is computed from a base address, the tile's column and row on the screen, and the screen pitch in bytes. While a clear or a flush is running, the block reports busy and ignores every new command and pixel store. A one-cycle done pulse marks the end of the flush.

Top module: `tile_store`

## Requirements
- R1: After reset, `busy`, `memValid` and `done` are low.
- R2: A pixel store with `pixValid` high while idle writes `pixColor` into tile row `pixY`, beat `pixX/8`, bits `[16*(pixX%8) +: 16]` of that beat's word. A later store to the same pixel overwrites the earlier value.
- R3: A `clearReq` taken while idle holds `busy` high for exactly 64 cycles. Afterwards every pixel holds the `clearColor` sampled with the request.
- R4: While `busy` is high, `pixValid`, `clearReq` and `flushReq` have no effect on the tile contents or on the block's sequencing.
- R5: A `flushReq` taken while idle raises `memValid` in the next cycle. The flush then emits exactly 64 beats in order: rows 0 to 15, and within each row beats 0 to 3 from left to right. Beat 0 of a row holds pixels 0 to 7, with pixel 0 in bits [15:0].
- R6: The address of beat b of row r is `baseAddr + (tileY*16 + r)*pitchBytes + tileX*64 + b*16`, using the values sampled with the request, modulo 2^32.
- R7: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memData` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the last beat is accepted. `busy` is low in that same cycle.
- R9: When `clearReq` and `flushReq` arrive together while idle, only the clear runs, and no beat is emitted.
- R10: A pixel stored in the same cycle that a flush is requested is included in the flushed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clearReq | input | 1 | Start filling the tile with `clearColor` |
| clearColor | input | 16 | Fill colour, sampled with `clearReq` |
| pixValid | input | 1 | Pixel store strobe |
| pixX | input | 5 | Pixel column within the tile |
| pixY | input | 4 | Pixel row within the tile |
| pixColor | input | 16 | Pixel colour |
| flushReq | input | 1 | Start copying the tile to memory |
| tileX | input | 8 | Tile column on the screen |
| tileY | input | 8 | Tile row on the screen |
| baseAddr | input | 32 | Framebuffer byte address of the screen origin |
| pitchBytes | input | 32 | Bytes per screen line |
| busy | output | 1 | Clear or flush in progress |
| memValid | output | 1 | Beat valid toward memory |
| memReady | input | 1 | Memory accepts the current beat |
| memAddr | output | 32 | Byte address of the current beat |
| memData | output | 128 | Eight pixels of the current beat |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The bench builds the block with its default parameters: a 32x16 tile of 16-bit pixels, a 128-bit bus and 32-bit addresses. With these values the four-beat row and the 64-beat flush run at their real length, and the lane and beat boundaries sit at pixel columns 7/8 and 31 as the requirements state them. Tile coordinates up to 255 and a screen-sized pitch exercise the full address arithmetic. Stores and commands issued during a clear or a flush, and memory stalls at random points, reach the ignore and hold rules in every phase of both sequences.

// File: rtl/tile_pkg.sv
package tile_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_FLUSH = 2'd2
  } tileState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchClear;  // capture fill colour
    logic latchFlush;  // capture flush geometry
    logic clrWrite;    // fill the word selected by wordIdx
    logic pixWrite;    // store the incoming pixel
  } tileStrobes_t;

endpackage

// File: rtl/tile_ctrl.sv
module tile_ctrl
  import tile_pkg::*;
#(
  parameter int NUM_WORDS = 64,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearReq,
  input  logic             flushReq,
  input  logic             pixValid,
  input  logic             memReady,
  output tileStrobes_t     strobes,
  output logic [IDX_W-1:0] wordIdx,
  output logic             busy,
  output logic             memValid,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  tileState_t       state;
  logic [IDX_W-1:0] cnt;
  logic             doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (clearReq)      state <= ST_CLEAR;
          else if (flushReq) state <= ST_FLUSH;
        end
        ST_CLEAR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= ST_IDLE;
        end
        ST_FLUSH: begin
          if (memReady) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_IDX) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latchClear = (state == ST_IDLE) && clearReq;
    strobes.latchFlush = (state == ST_IDLE) && !clearReq && flushReq;
    strobes.clrWrite   = (state == ST_CLEAR);
    strobes.pixWrite   = (state == ST_IDLE) && pixValid;
  end

  assign wordIdx  = cnt;
  assign busy     = (state != ST_IDLE);
  assign memValid = (state == ST_FLUSH);
  assign done     = doneQ;

  // done lasts one cycle only
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // done follows an accepted final beat
  assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(memValid && memReady && cnt == LAST_IDX));

endmodule

// File: rtl/tile_datapath.sv
module tile_datapath
  import tile_pkg::*;
#(
  parameter int TILE_W  = 32,
  parameter int TILE_H  = 16,
  parameter int PIX_W   = 16,
  parameter int BUS_W   = 128,
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 8,
  localparam int PIX_PER_WORD  = BUS_W / PIX_W,
  localparam int WORDS_PER_ROW = TILE_W / PIX_PER_WORD,
  localparam int NUM_WORDS     = WORDS_PER_ROW * TILE_H,
  localparam int IDX_W         = $clog2(NUM_WORDS),
  localparam int XW            = $clog2(TILE_W),
  localparam int YW            = $clog2(TILE_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tileStrobes_t       strobes,
  input  logic [IDX_W-1:0]   wordIdx,
  input  logic [XW-1:0]      pixX,
  input  logic [YW-1:0]      pixY,
  input  logic [PIX_W-1:0]   pixColor,
  input  logic [PIX_W-1:0]   clearColor,
  input  logic [COORD_W-1:0] tileX,
  input  logic [COORD_W-1:0] tileY,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [ADDR_W-1:0]  pitchBytes,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [BUS_W-1:0]   memData
);

  localparam int LANE_W     = $clog2(PIX_PER_WORD);
  localparam int COL_W      = $clog2(WORDS_PER_ROW);
  localparam int BEAT_BYTES = BUS_W / 8;
  localparam int ROW_BYTES  = TILE_W * PIX_W / 8;

  logic [BUS_W-1:0]   mem [NUM_WORDS];
  logic [PIX_W-1:0]   clrColorQ;
  logic [COORD_W-1:0] tileXQ, tileYQ;
  logic [ADDR_W-1:0]  baseQ, pitchQ;
  logic [BUS_W-1:0]   fillWord;

  logic [IDX_W-1:0]   pixIdx;
  logic [LANE_W-1:0]  pixLane;

  assign pixIdx  = {pixY, pixX[XW-1:LANE_W]};
  assign pixLane = pixX[LANE_W-1:0];

  for (genvar g = 0; g < PIX_PER_WORD; g++) begin : gFill
    assign fillWord[g*PIX_W +: PIX_W] = clrColorQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clrColorQ <= '0;
      tileXQ    <= '0;
      tileYQ    <= '0;
      baseQ     <= '0;
      pitchQ    <= '0;
    end else begin
      if (strobes.latchClear) clrColorQ <= clearColor;
      if (strobes.latchFlush) begin
        tileXQ <= tileX;
        tileYQ <= tileY;
        baseQ  <= baseAddr;
        pitchQ <= pitchBytes;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clrWrite)
      mem[wordIdx] <= fillWord;
    else if (strobes.pixWrite)
      mem[pixIdx][int'(pixLane)*PIX_W +: PIX_W] <= pixColor;
  end

  logic [YW-1:0]     beatRow;
  logic [COL_W-1:0]  beatCol;
  logic [ADDR_W-1:0] lineNum;

  assign beatRow = wordIdx[IDX_W-1:COL_W];
  assign beatCol = wordIdx[COL_W-1:0];
  assign lineNum = ADDR_W'(tileYQ) * ADDR_W'(TILE_H) + ADDR_W'(beatRow);

  assign memAddr = baseQ + lineNum * pitchQ
                 + ADDR_W'(tileXQ) * ADDR_W'(ROW_BYTES)
                 + ADDR_W'(beatCol) * ADDR_W'(BEAT_BYTES);
  assign memData = mem[wordIdx];

endmodule

// File: rtl/tile_store.sv
module tile_store
  import tile_pkg::*;
#(
  parameter int TILE_W  = 32,
  parameter int TILE_H  = 16,
  parameter int PIX_W   = 16,
  parameter int BUS_W   = 128,
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clearReq,
  input  logic [PIX_W-1:0]          clearColor,
  input  logic                      pixValid,
  input  logic [$clog2(TILE_W)-1:0] pixX,
  input  logic [$clog2(TILE_H)-1:0] pixY,
  input  logic [PIX_W-1:0]          pixColor,
  input  logic                      flushReq,
  input  logic [COORD_W-1:0]        tileX,
  input  logic [COORD_W-1:0]        tileY,
  input  logic [ADDR_W-1:0]         baseAddr,
  input  logic [ADDR_W-1:0]         pitchBytes,
  output logic                      busy,
  output logic                      memValid,
  input  logic                      memReady,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BUS_W-1:0]          memData,
  output logic                      done
);

  localparam int NUM_WORDS = (TILE_W / (BUS_W / PIX_W)) * TILE_H;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  tileStrobes_t     strobes;
  logic [IDX_W-1:0] wordIdx;

  tile_ctrl #(.NUM_WORDS(NUM_WORDS)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .clearReq(clearReq), .flushReq(flushReq),
    .pixValid(pixValid), .memReady(memReady),
    .strobes(strobes), .wordIdx(wordIdx),
    .busy(busy), .memValid(memValid), .done(done)
  );

  tile_datapath #(
    .TILE_W(TILE_W), .TILE_H(TILE_H), .PIX_W(PIX_W),
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .COORD_W(COORD_W)
  ) uData (
    .clk(clk), .rst_n(rst_n),
    .strobes(strobes), .wordIdx(wordIdx),
    .pixX(pixX), .pixY(pixY), .pixColor(pixColor),
    .clearColor(clearColor),
    .tileX(tileX), .tileY(tileY),
    .baseAddr(baseAddr), .pitchBytes(pitchBytes),
    .memAddr(memAddr), .memData(memData)
  );

  // A stalled beat stays offered unchanged
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> memValid);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> $stable(memAddr));

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    memValid && !memReady |=> $stable(memData));

endmodule

// File: tb/tb_tile_store.sv
module tb_tile_store;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clearReq = 1'b0;
  logic [15:0]  clearColor = '0;
  logic         pixValid = 1'b0;
  logic [4:0]   pixX = '0;
  logic [3:0]   pixY = '0;
  logic [15:0]  pixColor = '0;
  logic         flushReq = 1'b0;
  logic [7:0]   tileX = '0;
  logic [7:0]   tileY = '0;
  logic [31:0]  baseAddr = '0;
  logic [31:0]  pitchBytes = '0;
  logic         busy, memValid, done;
  logic         memReady = 1'b0;
  logic [31:0]  memAddr;
  logic [127:0] memData;

  int nChecks = 0;
  int nErrors = 0;

  logic [15:0] model [0:511];

  always #5 clk = ~clk;

  tile_store dut (
    .clk(clk), .rst_n(rst_n),
    .clearReq(clearReq), .clearColor(clearColor),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .pixColor(pixColor),
    .flushReq(flushReq), .tileX(tileX), .tileY(tileY),
    .baseAddr(baseAddr), .pitchBytes(pitchBytes),
    .busy(busy), .memValid(memValid), .memReady(memReady),
    .memAddr(memAddr), .memData(memData), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expWord(input int idx);
    logic [127:0] w;
    for (int lane = 0; lane < 8; lane++)
      w[lane*16 +: 16] = model[(idx / 4) * 32 + (idx % 4) * 8 + lane];
    return w;
  endfunction

  function automatic logic [31:0] expAddr(input logic [7:0] tx, input logic [7:0] ty,
                                          input logic [31:0] base, input logic [31:0] pitch,
                                          input int row, input int beat);
    return base + (32'(ty) * 32'd16 + 32'(row)) * pitch + 32'(tx) * 32'd64 + 32'(beat) * 32'd16;
  endfunction

  // Store n random pixels (R2), one per cycle
  task automatic randPixels(input int n);
    for (int i = 0; i < n; i++) begin
      pixValid = 1'b1;
      pixX = 5'($urandom % 32);
      pixY = 4'($urandom % 16);
      pixColor = 16'($urandom);
      model[int'(pixY) * 32 + int'(pixX)] = pixColor;
      @(negedge clk);
    end
    pixValid = 1'b0;
  endtask

  task automatic storePix(input int x, input int y, input logic [15:0] c);
    pixValid = 1'b1; pixX = 5'(x); pixY = 4'(y); pixColor = c;
    model[y * 32 + x] = c;
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  // Clear with optional junk stores during the clear (R3, R4)
  task automatic doClear(input logic [15:0] c, input bit junk);
    int cnt = 0;
    clearReq = 1'b1; clearColor = c;
    @(negedge clk);
    clearReq = 1'b0;
    clearColor = ~c;
    while (busy && cnt < 200) begin
      cnt++;
      pixValid = junk; pixX = 5'($urandom); pixY = 4'($urandom); pixColor = 16'($urandom);
      flushReq = junk && ($urandom % 8 == 0);
      @(negedge clk);
      pixValid = 1'b0; flushReq = 1'b0;
    end
    check(cnt == 64, "R3 busy length of clear", 128'(cnt), 128'd64);
    check(!memValid, "R4 flushReq during clear ignored", 128'(memValid), 128'd0);
    for (int i = 0; i < 512; i++) model[i] = c;
  endtask

  // Flush and check every beat (R5, R6, R7, R8), optional junk (R4)
  task automatic doFlush(input logic [7:0] tx, input logic [7:0] ty,
                         input logic [31:0] base, input logic [31:0] pitch, input bit junk);
    int k = 0;
    int guard = 0;
    bit stalled = 1'b0;
    logic [31:0] prevAddr = '0;
    logic [127:0] prevData = '0;
    tileX = tx; tileY = ty; baseAddr = base; pitchBytes = pitch;
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0; pixValid = 1'b0;
    tileX = ~tx; tileY = ~ty; baseAddr = ~base; pitchBytes = ~pitch;
    while (k < 64 && guard < 5000) begin
      guard++;
      pixValid = 1'b0; clearReq = 1'b0; flushReq = 1'b0;
      check(memValid == 1'b1, "R5 memValid during flush", 128'(memValid), 128'd1);
      check(done == 1'b0, "R8 no early done", 128'(done), 128'd0);
      if (stalled) begin
        check(memAddr == prevAddr, "R7 address held while stalled", 128'(memAddr), 128'(prevAddr));
        check(memData == prevData, "R7 data held while stalled", memData, prevData);
      end
      check(memAddr == expAddr(tx, ty, base, pitch, k / 4, k % 4), "R6 beat address",
            128'(memAddr), 128'(expAddr(tx, ty, base, pitch, k / 4, k % 4)));
      check(memData == expWord(k), "R5 R2 beat data", memData, expWord(k));
      memReady = ($urandom % 3 != 0);
      if (junk) begin
        pixValid = 1'b1; pixX = 5'($urandom); pixY = 4'($urandom); pixColor = 16'($urandom);
        clearReq = ($urandom % 6 == 0);
        flushReq = ($urandom % 6 == 0);
      end
      prevAddr = memAddr; prevData = memData; stalled = !memReady;
      if (memReady) k++;
      @(negedge clk);
    end
    memReady = 1'b0; pixValid = 1'b0; clearReq = 1'b0; flushReq = 1'b0;
    check(k == 64, "R5 beat count", 128'(k), 128'd64);
    check(done == 1'b1, "R8 done after last beat", 128'(done), 128'd1);
    check(busy == 1'b0, "R8 busy low with done", 128'(busy), 128'd0);
    check(memValid == 1'b0, "R5 no beat after 64", 128'(memValid), 128'd0);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", 128'(busy), 128'd0);
    check(memValid == 1'b0, "R1 memValid after reset", 128'(memValid), 128'd0);
    check(done == 1'b0, "R1 done after reset", 128'(done), 128'd0);

    // R3 plain clear, then flush of uniform tile at origin
    doClear(16'h1234, 1'b0);
    doFlush(8'd0, 8'd0, 32'd0, 32'd1280, 1'b0);

    // R2 directed corners and overwrite
    storePix(0, 0, 16'hAAAA);
    storePix(7, 0, 16'hBBBB);
    storePix(8, 0, 16'hCCCC);
    storePix(31, 15, 16'h1111);
    storePix(31, 15, 16'h2222);
    randPixels(300);
    doFlush(8'd3, 8'd2, 32'h0001_0000, 32'd1280, 1'b1);

    // R10 pixel stored with the flush request
    pixValid = 1'b1; pixX = 5'd17; pixY = 4'd9; pixColor = 16'hBEEF;
    model[9 * 32 + 17] = 16'hBEEF;
    doFlush(8'd255, 8'd255, 32'hFFFF_0000, 32'd4096, 1'b0);

    // R9 simultaneous clear and flush
    begin
      int cnt = 0;
      int vis = 0;
      clearReq = 1'b1; flushReq = 1'b1; clearColor = 16'h0F0F;
      @(negedge clk);
      clearReq = 1'b0; flushReq = 1'b0;
      while (busy && cnt < 200) begin
        cnt++;
        if (memValid) vis++;
        @(negedge clk);
      end
      check(cnt == 64, "R9 clear wins, length", 128'(cnt), 128'd64);
      check(vis == 0, "R9 no beats when both requested", 128'(vis), 128'd0);
      for (int i = 0; i < 512; i++) model[i] = 16'h0F0F;
    end
    doFlush(8'd1, 8'd1, 32'd0, 32'd2048, 1'b0);

    // R4 junk during clear, then random content
    doClear(16'h7E57, 1'b1);
    randPixels(200);
    doFlush(8'($urandom), 8'($urandom), 32'($urandom), 32'd2560, 1'b1);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule